// File: doc/BRIEF.md
# Six-Channel Toggle Compare Unit

This block watches a shared 16-bit free-running count and a count-tick strobe. It holds six compare channels. On a tick where the count equals a channel's active compare value, that channel inverts its output latch and raises its own sticky interrupt flag. Each compare value can be written straight into the active register. It can instead be written into a holding register that is copied over when the count passes through zero, so a running waveform changes period only at a clean boundary.

Neighbouring channels form three pairs: (0,1), (2,3) and (4,5). When a pair is joined, a match on either channel inverts the even channel's pin, so two compare values shape one waveform. Software can preset the level of any disabled channel's latch before the channel starts.

All configuration goes through one write port with a 4-bit address. Addresses 0 to 5 are the compare values. Address 8 holds the enable bits, address 9 the buffer-select bits and address 11 the pair bits. A write to address 10 presets latch levels, and a write to address 12 clears flags. Bit n of each channel-indexed word refers to channel n, and bit p of the pair word refers to pair p.

Top module: `ocu_top`

## Requirements
- R1: After a synchronous reset, every pin is low, every flag is clear, every compare value is 0x0000, and all enable, buffer, pair and preset state is zero.
- R2: When cnt_tick is high, enable bit n (address 8) is set and cnt_val equals channel n's active compare value, pin n inverts at that clock edge. This is visible the cycle after the tick.
- R3: No pin inverts and no flag sets on a cycle with cnt_tick low, whatever the count. A channel whose enable bit is clear never matches.
- R4: With buffer-select bit n (address 9) clear, a write to address n becomes channel n's active compare value from the next clock edge.
- R5: With buffer-select bit n set, a write to address n goes only to the holding register. The holding value is copied to the active register on a tick with cnt_val equal to 0x0000. The compare made on that same tick still uses the previous active value.
- R6: With pair bit p (address 11) set, pin 2p inverts on a match of channel 2p or channel 2p+1, and only once if both match on the same tick. Pin 2p+1 keeps its level.
- R7: Flag n sets on every match of channel n, including when the channel is paired. It stays set until a write to address 12 with bit n high. If a set and a clear happen on the same cycle, the set wins.
- R8: A write to address 10 loads bit n into pin n's latch for every channel whose enable bit is clear. Channels that are enabled ignore it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | 16 | Shared free-running count value |
| cnt_tick | input | 1 | High on cycles where the count has advanced |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| pin_out | output | 6 | Output latch levels, bit n is channel n |
| irq_flag | output | 6 | Sticky match flags, bit n is channel n |

## Verification
The bench sweeps the count across every value up to each compare point, for all six channels at once. It tracks the expected pin levels and flags arithmetically, so a toggle that fires on a missed tick, fires twice, or lands on the wrong channel shows up as a mismatch. Buffered reloads are swept through a zero crossing. A design that copies the holding value early would toggle at the new value before the wrap, and one that never copies it would keep toggling at the old value after the wrap. Paired channels are tested with distinct and with identical compare values: a design that toggles twice on a shared match leaves the even pin unchanged, and one that lets the odd pin move breaks the hold check. The bench also covers a flag clear that arrives on a matching tick, and a preset written to a mix of enabled and disabled channels.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
    localparam int CW = 16;
    localparam int AW = 4;

    localparam logic [AW-1:0] ADR_EN   = 4'd8;
    localparam logic [AW-1:0] ADR_BSEL = 4'd9;
    localparam logic [AW-1:0] ADR_INIT = 4'd10;
    localparam logic [AW-1:0] ADR_PAIR = 4'd11;
    localparam logic [AW-1:0] ADR_CLR  = 4'd12;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
        logic [CW-1:0] data;
    } wr_req_t;

    function automatic logic hits(wr_req_t r, logic [AW-1:0] a);
        return r.en && (r.addr == a);
    endfunction
endpackage

// File: rtl/ocu_ctrl.sv
module ocu_ctrl
    import ocu_pkg::*;
#(
    parameter int N_CH = 6,
    localparam int N_PAIR = N_CH / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [N_CH-1:0]   wr_bits,
    output logic [N_CH-1:0]   en_q,
    output logic [N_CH-1:0]   bsel_q,
    output logic [N_PAIR-1:0] pair_q,
    output logic              init_wr,
    output logic              clr_wr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            bsel_q <= '0;
            pair_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADR_EN)   en_q   <= wr_bits;
            if (wr_addr == ADR_BSEL) bsel_q <= wr_bits;
            if (wr_addr == ADR_PAIR) pair_q <= wr_bits[N_PAIR-1:0];
        end
    end

    assign init_wr = wr_en && (wr_addr == ADR_INIT);
    assign clr_wr  = wr_en && (wr_addr == ADR_CLR);
endmodule

// File: rtl/ocu_cmp_chan.sv
module ocu_cmp_chan
    import ocu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_hit,
    input  logic [CW-1:0] wr_data,
    input  logic          buffered,
    input  logic          enable,
    input  logic [CW-1:0] cnt_val,
    input  logic          cnt_tick,
    output logic          match
);
    logic [CW-1:0] hold_q;
    logic [CW-1:0] active_q;
    logic          wrap;

    assign wrap = cnt_tick && (cnt_val == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q   <= '0;
            active_q <= '0;
        end else begin
            if (wr_hit) hold_q <= wr_data;
            if (wr_hit && !buffered) active_q <= wr_data;
            else if (buffered && wrap) active_q <= hold_q;
        end
    end

    assign match = cnt_tick && enable && (cnt_val == active_q);

    assert_direct_load_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && !buffered) |=> (active_q == $past(wr_data)));

    assert_buf_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (buffered && !wrap) |=> $stable(active_q));

    assert_buf_xfer_R5: assert property (@(posedge clk) disable iff (rst)
        (buffered && wrap) |=> (active_q == $past(hold_q)));
endmodule

// File: rtl/ocu_pin_bank.sv
module ocu_pin_bank #(
    parameter int N_CH = 6,
    localparam int N_PAIR = N_CH / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_CH-1:0]   match,
    input  logic [N_CH-1:0]   en_q,
    input  logic [N_PAIR-1:0] pair_q,
    input  logic              init_wr,
    input  logic              clr_wr,
    input  logic [N_CH-1:0]   wr_bits,
    output logic [N_CH-1:0]   latch_q,
    output logic [N_CH-1:0]   flag_q
);
    logic [N_CH-1:0] tog;

    for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
        assign tog[2*p]   = match[2*p] | (pair_q[p] & match[2*p+1]);
        assign tog[2*p+1] = match[2*p+1] & ~pair_q[p];

        assert_odd_hold_R6: assert property (@(posedge clk) disable iff (rst)
            (pair_q[p] && !init_wr) |=> $stable(latch_q[2*p+1]));

        assert_even_inv_R2: assert property (@(posedge clk) disable iff (rst)
            (match[2*p] && !init_wr) |=> (latch_q[2*p] != $past(latch_q[2*p])));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            flag_q  <= '0;
        end else begin
            for (int i = 0; i < N_CH; i++) begin
                if (init_wr && !en_q[i]) latch_q[i] <= wr_bits[i];
                else                     latch_q[i] <= latch_q[i] ^ tog[i];
                flag_q[i] <= match[i] | (flag_q[i] & ~(clr_wr & wr_bits[i]));
            end
        end
    end

    for (genvar i = 0; i < N_CH; i++) begin : g_flag
        assert_flag_set_R7: assert property (@(posedge clk) disable iff (rst)
            match[i] |=> flag_q[i]);
    end
endmodule

// File: rtl/ocu_top.sv
module ocu_top
    import ocu_pkg::*;
#(
    parameter int N_CH = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [15:0]   cnt_val,
    input  logic          cnt_tick,
    input  logic          wr_en,
    input  logic [3:0]    wr_addr,
    input  logic [15:0]   wr_data,
    output logic [5:0]    pin_out,
    output logic [5:0]    irq_flag
);
    localparam int N_PAIR = N_CH / 2;

    wr_req_t           req;
    logic [N_CH-1:0]   en_q;
    logic [N_CH-1:0]   bsel_q;
    logic [N_PAIR-1:0] pair_q;
    logic              init_wr;
    logic              clr_wr;
    logic [N_CH-1:0]   match;

    assign req = '{en: wr_en, addr: wr_addr, data: wr_data};

    ocu_ctrl #(.N_CH(N_CH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (req.en),
        .wr_addr (req.addr),
        .wr_bits (req.data[N_CH-1:0]),
        .en_q    (en_q),
        .bsel_q  (bsel_q),
        .pair_q  (pair_q),
        .init_wr (init_wr),
        .clr_wr  (clr_wr)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        ocu_cmp_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .wr_hit   (hits(req, AW'(i))),
            .wr_data  (req.data),
            .buffered (bsel_q[i]),
            .enable   (en_q[i]),
            .cnt_val  (cnt_val),
            .cnt_tick (cnt_tick),
            .match    (match[i])
        );
    end

    ocu_pin_bank #(.N_CH(N_CH)) u_pins (
        .clk     (clk),
        .rst     (rst),
        .match   (match),
        .en_q    (en_q),
        .pair_q  (pair_q),
        .init_wr (init_wr),
        .clr_wr  (clr_wr),
        .wr_bits (req.data[N_CH-1:0]),
        .latch_q (pin_out),
        .flag_q  (irq_flag)
    );

    assert_no_tick_R3: assert property (@(posedge clk) disable iff (rst)
        (!cnt_tick && !init_wr) |=> $stable(pin_out));

    assert_no_tick_flag_R3: assert property (@(posedge clk) disable iff (rst)
        !cnt_tick |=> ((irq_flag & ~$past(irq_flag)) == '0));
endmodule

// File: tb/ocu_top_bench.sv
module ocu_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cnt_val = '0;
    logic        cnt_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [5:0]  pin_out;
    logic [5:0]  irq_flag;

    int errors = 0;
    int checks = 0;

    logic [15:0] m_act [6];
    logic [15:0] m_buf [6];
    logic [5:0]  m_en, m_bs, m_pin, m_flag;
    logic [2:0]  m_pair;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocu_top u_ocu_top (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_tick(cnt_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pin_out(pin_out), .irq_flag(irq_flag)
    );

    task automatic model_reset();
        for (int i = 0; i < 6; i++) begin
            m_act[i] = '0;
            m_buf[i] = '0;
        end
        m_en = '0; m_bs = '0; m_pin = '0; m_flag = '0; m_pair = '0;
    endtask

    task automatic model_edge(input logic w, input logic [3:0] a,
                              input logic [15:0] d, input logic [15:0] c,
                              input logic t);
        logic [5:0] m, tg, npin, nflag;
        for (int i = 0; i < 6; i++)
            m[i] = t && m_en[i] && (c == m_act[i]);
        for (int p = 0; p < 3; p++) begin
            tg[2*p]   = m[2*p] | (m_pair[p] & m[2*p+1]);
            tg[2*p+1] = m_pair[p] ? 1'b0 : m[2*p+1];
        end
        npin  = m_pin ^ tg;
        nflag = m_flag;
        if (w && a == 4'd12) nflag = nflag & ~d[5:0];
        nflag = nflag | m;
        if (t && c == 16'd0)
            for (int i = 0; i < 6; i++)
                if (m_bs[i]) m_act[i] = m_buf[i];
        if (w) begin
            if (a < 4'd6) begin
                m_buf[a] = d;
                if (!m_bs[a]) m_act[a] = d;
            end
            if (a == 4'd10)
                for (int i = 0; i < 6; i++)
                    if (!m_en[i]) npin[i] = d[i];
            if (a == 4'd8)  m_en   = d[5:0];
            if (a == 4'd9)  m_bs   = d[5:0];
            if (a == 4'd11) m_pair = d[2:0];
        end
        m_pin  = npin;
        m_flag = nflag;
    endtask

    task automatic step(input logic w, input logic [3:0] a, input logic [15:0] d,
                        input logic [15:0] c, input logic t);
        wr_en = w; wr_addr = a; wr_data = d; cnt_val = c; cnt_tick = t;
        @(posedge clk);
        model_edge(w, a, d, c, t);
        @(negedge clk);
        wr_en = 1'b0; cnt_tick = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        step(1'b1, a, d, 16'd100, 1'b0);
    endtask

    task automatic tick(input logic [15:0] c);
        step(1'b0, 4'd0, 16'd0, c, 1'b1);
    endtask

    task automatic chk(input string tag);
        checks++;
        if (pin_out !== m_pin || irq_flag !== m_flag) begin
            errors++;
            $display("FAIL %s: pin=%b flag=%b expected pin=%b flag=%b",
                     tag, pin_out, irq_flag, m_pin, m_flag);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset state");

        // R1: compare values reset to zero, so all enabled channels hit at 0
        wr(4'd8, 16'h003f);
        tick(16'd0);
        chk("R1 zero compare");
        wr(4'd12, 16'h003f);
        chk("R7 clear flags");

        // R2/R4: sweep with distinct compare points
        for (int i = 0; i < 6; i++) wr(4'(i), 16'(3 + 5 * i));
        for (int c = 1; c <= 40; c++) begin
            tick(16'(c));
            chk("R2 sweep");
        end

        // R3: matching count without tick
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 4'd0, 16'd0, 16'd8, 1'b0);
            chk("R3 no tick");
        end
        wr(4'd8, 16'h003b);
        for (int c = 10; c <= 15; c++) begin
            tick(16'(c));
            chk("R3 disabled channel");
        end

        // R8: preset on mixed enabled/disabled
        wr(4'd10, 16'h002a);
        chk("R8 preset low");
        wr(4'd10, 16'h0004);
        chk("R8 preset high");
        wr(4'd8, 16'h003f);

        // R5: buffered reload across a wrap
        wr(4'd12, 16'h003f);
        wr(4'd9, 16'h0002);
        wr(4'd1, 16'd30);
        for (int c = 5; c <= 35; c++) begin
            tick(16'(c));
            chk("R5 before wrap");
        end
        tick(16'd0);
        chk("R5 wrap");
        for (int c = 1; c <= 35; c++) begin
            tick(16'(c));
            chk("R5 after wrap");
        end
        wr(4'd9, 16'h0000);

        // R4: direct load takes effect next edge
        wr(4'd0, 16'd2);
        tick(16'd2);
        chk("R4 direct load");

        // R6: pairing
        wr(4'd11, 16'h0001);
        wr(4'd0, 16'd5);
        wr(4'd1, 16'd9);
        for (int c = 0; c <= 12; c++) begin
            tick(16'(c));
            chk("R6 pair sweep");
        end
        wr(4'd1, 16'd5);
        tick(16'd5);
        chk("R6 shared match once");
        wr(4'd11, 16'h0007);
        for (int i = 0; i < 6; i++) wr(4'(i), 16'(2 + 3 * i));
        for (int c = 0; c <= 20; c++) begin
            tick(16'(c));
            chk("R6 all pairs");
        end

        // R7: set wins over clear on the same cycle
        wr(4'd12, 16'h003f);
        chk("R7 cleared");
        step(1'b1, 4'd12, 16'h003f, 16'd8, 1'b1);
        chk("R7 set wins");
        tick(16'd30);
        chk("R7 sticky");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule